// File: doc/BRIEF.md
# Direction-Switched Word FIFO with Status Flags

This block is a single 32-entry, 32-bit word buffer shared by two transfer directions. A data-path engine picks the direction at run time with two activity inputs that are never high together. With the transmit input high, the host fills the buffer through a register-bus window and the engine drains it. With the receive input high, the engine fills the buffer and the host drains it. With both inputs low, the buffer is idle and all of its status flags read low.

On the host side, any of 32 consecutive word addresses reaches the single push or pop point, so a burst may step through the window without changing the order of the data. On the engine side, a registered output always shows the oldest transmit word, and a one-cycle pop strobe moves to the next word. A push strobe stores a received word. The status flags report full, empty, data available and a direction-dependent half mark for DMA requests. Sticky error bits record a transmit underrun or a receive overrun until a clear strobe removes them. Everything runs on one clock with a synchronous active-high reset.

Top module: `bidir_word_fifo`

## Requirements
- R1: With both activity inputs low (idle), every status flag output is low, and host writes, host reads and engine strobes have no effect on the stored contents.
- R2: Any idle cycle, and the first cycle of a direct switch between transmit and receive, empties the buffer (count and both pointers to zero). In the cycle after such a flush that is in an active mode, flag_empty reads 1.
- R3: A host write or read is part of the window only when host_addr >> 5 equals WIN_BASE >> 5 (with defaults, addresses 0x20 to 0x3F). All 32 addresses in the window reach the same push or pop point in arrival order, and accesses outside the window are ignored. Host writes act only in transmit mode and host reads only in receive mode.
- R4: In transmit mode, eng_txdata, sampled after a clock edge, holds the oldest stored word whenever the buffer is not empty. An eng_pop strobe on a non-empty buffer moves the output to the next word at the following edge.
- R5: An eng_pop in transmit mode while the buffer is empty sets the sticky underrun bit. The read pointer does not move and eng_txdata stays unchanged.
- R6: In receive mode, eng_push stores eng_rxdata at the tail. host_rdata shows the oldest stored word combinationally, and a host read in the window removes it. Outside receive mode, host_rdata is zero.
- R7: An eng_push in receive mode while the buffer holds 32 words sets the sticky overrun bit and drops the word.
- R8: flag_full is 1 when 32 words are stored, flag_empty is 1 when none are stored, and flag_avail is the inverse of flag_empty while a mode is active.
- R9: flag_half is 1 in transmit mode when 8 or more entries are free (count of 24 or less), and in receive mode when 8 or more words are stored.
- R10: err_clr clears both sticky bits at the next edge. An error event in the same cycle as err_clr wins, so its bit is set. The sticky bits keep their value through idle periods, but the flag outputs are masked low while idle.
- R11: Accept decisions use the count from before the edge. A push and a pop accepted in the same cycle leave the count unchanged. A push into a full buffer is dropped even if a pop is accepted in the same cycle, and a transmit-mode host write to a full buffer is dropped without setting an error.
- R12: After reset, the buffer is empty, both sticky bits are clear and every flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_tx_mode | input | 1 | Engine transmit activity (selects transmit mode) |
| eng_rx_mode | input | 1 | Engine receive activity (selects receive mode) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, oldest word in receive mode |
| err_clr | input | 1 | Clear strobe for both sticky error bits |
| eng_pop | input | 1 | Engine has taken the presented transmit word |
| eng_txdata | output | DATA_W | Registered transmit word at the read pointer |
| eng_push | input | 1 | Engine stores a received word |
| eng_rxdata | input | DATA_W | Received word from the engine |
| flag_full | output | 1 | All entries valid |
| flag_empty | output | 1 | No entry valid |
| flag_half | output | 1 | Transmit: 8 or more free; receive: 8 or more valid |
| flag_avail | output | 1 | At least one entry valid |
| flag_underrun | output | 1 | Sticky transmit underrun |
| flag_overrun | output | 1 | Sticky receive overrun |

## Verification
The bound checker tests these rules on every cycle: the flag outputs stay quiet while idle, the buffer reads empty after a flush, full and empty never hold together, the error bits are set by a pop on an empty buffer or a push on a full one, and they stay set until a clear. It also checks that the transmit word holds still while the buffer is empty and that a full transmit buffer stays full without a pop. Only the bench's reference queue can show that data leaves in arrival order across the whole address window. The same holds for the pass-through of a word written in the same cycle it becomes the head, and for the half-mark thresholds in both directions. It also covers dropped words on full or empty, and the flush on a direct switch between modes.

// File: rtl/bwf_pkg.sv
package bwf_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10
    } fifo_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic half;
        logic avail;
        logic underrun;
        logic overrun;
    } fifo_flags_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic underrun_evt;
        logic overrun_evt;
    } fifo_ops_t;

    function automatic fifo_mode_e decode_mode(input logic tx, input logic rx);
        if (tx && !rx) return MODE_TX;
        if (rx && !tx) return MODE_RX;
        return MODE_IDLE;
    endfunction

endpackage

// File: rtl/bwf_mode_ctrl.sv
module bwf_mode_ctrl
    import bwf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_act,
    input  logic       rx_act,
    output fifo_mode_e mode,
    output logic       flush
);

    fifo_mode_e mode_q;

    assign mode = decode_mode(tx_act, rx_act);

    // Idle empties the buffer; a direct hop between directions also does.
    assign flush = (mode == MODE_IDLE) ||
                   ((mode_q != MODE_IDLE) && (mode != mode_q));

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_IDLE;
        else     mode_q <= mode;
    end

endmodule

// File: rtl/bwf_ptr_ctrl.sv
module bwf_ptr_ctrl
    import bwf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_mode_e       mode,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output fifo_ops_t        ops,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] rptr_nxt,
    output logic [CNT_W-1:0] count
);

    logic is_empty, is_full;

    assign is_empty = (count == '0);
    assign is_full  = (count == CNT_W'(DEPTH));

    always_comb begin
        ops.push         = !flush && push_req && !is_full;
        ops.pop          = !flush && pop_req  && !is_empty;
        ops.underrun_evt = !flush && (mode == MODE_TX) && pop_req  && is_empty;
        ops.overrun_evt  = !flush && (mode == MODE_RX) && push_req && is_full;
    end

    always_comb begin
        if (flush)        rptr_nxt = '0;
        else if (ops.pop) rptr_nxt = rptr + PTR_W'(1);
        else              rptr_nxt = rptr;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            rptr <= rptr_nxt;
            if (ops.push) wptr <= wptr + PTR_W'(1);
            case ({ops.push, ops.pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bwf_store.sv
module bwf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [PTR_W-1:0]  rd_ptr_nxt,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] head_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

    // Head register follows the next read pointer; a word landing on that
    // slot in the same edge is passed straight through.
    always_ff @(posedge clk) begin
        if (rst)                                head_q <= '0;
        else if (wr_en && wr_ptr == rd_ptr_nxt) head_q <= wr_data;
        else                                    head_q <= mem[rd_ptr_nxt];
    end

endmodule

// File: rtl/bwf_flags.sv
module bwf_flags
    import bwf_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int HALF_MARK = 8,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_mode_e       mode,
    input  logic [CNT_W-1:0] count,
    input  logic             underrun_evt,
    input  logic             overrun_evt,
    input  logic             err_clr,
    output fifo_flags_t      flags
);

    logic             und_q, ovr_q, en;
    logic [CNT_W-1:0] free_slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            und_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (underrun_evt) und_q <= 1'b1;
            else if (err_clr) und_q <= 1'b0;
            if (overrun_evt)  ovr_q <= 1'b1;
            else if (err_clr) ovr_q <= 1'b0;
        end
    end

    assign en         = (mode != MODE_IDLE);
    assign free_slots = CNT_W'(DEPTH) - count;

    always_comb begin
        flags.full     = en && (count == CNT_W'(DEPTH));
        flags.empty    = en && (count == '0);
        flags.avail    = en && (count != '0);
        flags.underrun = en && und_q;
        flags.overrun  = en && ovr_q;
        case (mode)
            MODE_TX: flags.half = (free_slots >= CNT_W'(HALF_MARK));
            MODE_RX: flags.half = (count >= CNT_W'(HALF_MARK));
            default: flags.half = 1'b0;
        endcase
    end

endmodule

// File: rtl/bidir_word_fifo.sv
module bidir_word_fifo
    import bwf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 32,
    parameter int HADDR_W   = 8,
    parameter int WIN_BASE  = 32,
    parameter int HALF_MARK = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eng_tx_mode,
    input  logic               eng_rx_mode,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               err_clr,
    input  logic               eng_pop,
    output logic [DATA_W-1:0]  eng_txdata,
    input  logic               eng_push,
    input  logic [DATA_W-1:0]  eng_rxdata,
    output logic               flag_full,
    output logic               flag_empty,
    output logic               flag_half,
    output logic               flag_avail,
    output logic               flag_underrun,
    output logic               flag_overrun
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    fifo_mode_e        mode;
    logic              flush, win_hit, push_req, pop_req;
    fifo_ops_t         ops;
    fifo_flags_t       flags;
    logic [PTR_W-1:0]  wptr, rptr, rptr_nxt;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] wr_data, rd_data;

    // Every word address inside the window reaches the same port.
    assign win_hit = ((host_addr >> PTR_W) == (HADDR_W'(WIN_BASE) >> PTR_W));

    always_comb begin
        case (mode)
            MODE_TX: begin
                push_req = host_wr && win_hit;
                pop_req  = eng_pop;
                wr_data  = host_wdata;
            end
            MODE_RX: begin
                push_req = eng_push;
                pop_req  = host_rd && win_hit;
                wr_data  = eng_rxdata;
            end
            default: begin
                push_req = 1'b0;
                pop_req  = 1'b0;
                wr_data  = '0;
            end
        endcase
    end

    bwf_mode_ctrl u_mode (
        .clk    (clk),
        .rst    (rst),
        .tx_act (eng_tx_mode),
        .rx_act (eng_rx_mode),
        .mode   (mode),
        .flush  (flush)
    );

    bwf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .flush    (flush),
        .push_req (push_req),
        .pop_req  (pop_req),
        .ops      (ops),
        .wptr     (wptr),
        .rptr     (rptr),
        .rptr_nxt (rptr_nxt),
        .count    (count)
    );

    bwf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ops.push),
        .wr_ptr     (wptr),
        .wr_data    (wr_data),
        .rd_ptr     (rptr),
        .rd_ptr_nxt (rptr_nxt),
        .rd_data    (rd_data),
        .head_q     (eng_txdata)
    );

    bwf_flags #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .count        (count),
        .underrun_evt (ops.underrun_evt),
        .overrun_evt  (ops.overrun_evt),
        .err_clr      (err_clr),
        .flags        (flags)
    );

    assign host_rdata    = (mode == MODE_RX) ? rd_data : '0;
    assign flag_full     = flags.full;
    assign flag_empty    = flags.empty;
    assign flag_half     = flags.half;
    assign flag_avail    = flags.avail;
    assign flag_underrun = flags.underrun;
    assign flag_overrun  = flags.overrun;

endmodule

// File: rtl/bwf_checker.sv
module bwf_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              eng_tx_mode,
    input logic              eng_rx_mode,
    input logic              host_wr,
    input logic              eng_pop,
    input logic              eng_push,
    input logic              err_clr,
    input logic [DATA_W-1:0] eng_txdata,
    input logic              flag_full,
    input logic              flag_empty,
    input logic              flag_half,
    input logic              flag_avail,
    input logic              flag_underrun,
    input logic              flag_overrun
);

    logic tx, rx, idle;
    assign tx   = eng_tx_mode && !eng_rx_mode;
    assign rx   = eng_rx_mode && !eng_tx_mode;
    assign idle = !eng_tx_mode && !eng_rx_mode;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        idle |-> !(flag_full || flag_empty || flag_half || flag_avail ||
                   flag_underrun || flag_overrun));

    assert_restart_empty_R2: assert property (@(posedge clk) disable iff (rst)
        ((tx || rx) && $past(idle)) |-> (flag_empty && !flag_full));

    assert_avail_inverse_R8: assert property (@(posedge clk) disable iff (rst)
        (tx || rx) |-> ((flag_avail != flag_empty) && !(flag_full && flag_empty)));

    assert_half_at_full_R9: assert property (@(posedge clk) disable iff (rst)
        flag_full |-> (tx ? !flag_half : flag_half));

    assert_underrun_set_R5: assert property (@(posedge clk) disable iff (rst)
        (tx && $past(tx) && $past(tx, 2) && $past(flag_empty) && $past(eng_pop))
        |-> flag_underrun);

    assert_txdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx && $past(tx) && flag_empty && !host_wr) |=> $stable(eng_txdata));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
        (rx && $past(rx) && $past(rx, 2) && $past(flag_full) && $past(eng_push))
        |-> flag_overrun);

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx && $past(tx) && $past(flag_underrun) && !$past(err_clr))
        |-> flag_underrun);

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ((tx || rx) && $past(err_clr) && !$past(eng_pop) && !$past(eng_push))
        |-> (!flag_underrun && !flag_overrun));

    assert_full_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (tx && $past(tx) && $past(tx, 2) && $past(flag_full) && !$past(eng_pop))
        |-> flag_full);

endmodule

bind bidir_word_fifo bwf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .eng_tx_mode   (eng_tx_mode),
    .eng_rx_mode   (eng_rx_mode),
    .host_wr       (host_wr),
    .eng_pop       (eng_pop),
    .eng_push      (eng_push),
    .err_clr       (err_clr),
    .eng_txdata    (eng_txdata),
    .flag_full     (flag_full),
    .flag_empty    (flag_empty),
    .flag_half     (flag_half),
    .flag_avail    (flag_avail),
    .flag_underrun (flag_underrun),
    .flag_overrun  (flag_overrun)
);

// File: tb/bidir_word_fifo_test.sv
module bidir_word_fifo_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eng_tx_mode = 0, eng_rx_mode = 0;
    logic        host_wr = 0, host_rd = 0, err_clr = 0, eng_pop = 0, eng_push = 0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, eng_rxdata = '0;
    logic [31:0] host_rdata, eng_txdata;
    logic        flag_full, flag_empty, flag_half, flag_avail, flag_underrun, flag_overrun;

    bidir_word_fifo uut (
        .clk(clk), .rst(rst), .eng_tx_mode(eng_tx_mode), .eng_rx_mode(eng_rx_mode),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .err_clr(err_clr),
        .eng_pop(eng_pop), .eng_txdata(eng_txdata), .eng_push(eng_push),
        .eng_rxdata(eng_rxdata), .flag_full(flag_full), .flag_empty(flag_empty),
        .flag_half(flag_half), .flag_avail(flag_avail),
        .flag_underrun(flag_underrun), .flag_overrun(flag_overrun)
    );

    always #10 clk = ~clk;

    int          vectors = 0, miscompares = 0;
    bit          finished = 0;
    string       ctx = "";
    logic [31:0] q[$];
    bit          und = 0, ovr = 0;
    int          mprev = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL [%s] %s: actual %h expected %h", ctx, tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int m  = eng_tx_mode ? 1 : (eng_rx_mode ? 2 : 0);
        bit en = (m != 0);
        int sz = q.size();
        chk(en ? "R8 full"  : "R1 full",  32'(flag_full),  32'(en && sz == 32));
        chk(en ? "R8 empty" : "R1 empty", 32'(flag_empty), 32'(en && sz == 0));
        chk(en ? "R8 avail" : "R1 avail", 32'(flag_avail), 32'(en && sz != 0));
        chk(en ? "R9 half"  : "R1 half",  32'(flag_half),
            32'((m == 1) ? (32 - sz >= 8) : ((m == 2) ? (sz >= 8) : 0)));
        chk(en ? "R5 underrun" : "R1 underrun", 32'(flag_underrun), 32'(en && und));
        chk(en ? "R7 overrun"  : "R1 overrun",  32'(flag_overrun),  32'(en && ovr));
        if (m == 1 && sz > 0) chk("R4 txdata", eng_txdata, q[0]);
        if (m == 2 && sz > 0) chk("R6 rdata", host_rdata, q[0]);
        if (m != 2)           chk("R6 rdata outside rx", host_rdata, 32'h0);
    endtask

    task automatic model_update();
        int m     = eng_tx_mode ? 1 : (eng_rx_mode ? 2 : 0);
        bit hit   = (host_addr[7:5] == 3'b001);
        bit flush = (m == 0) || (mprev != 0 && m != mprev);
        bit uev = 0, oev = 0, pu = 0, pr = 0;
        logic [31:0] d = '0;
        int pre = q.size();
        if (flush) q.delete();
        else begin
            if (m == 1) begin
                pr = eng_pop; pu = host_wr && hit; d = host_wdata;
                uev = eng_pop && pre == 0;
            end else begin
                pu = eng_push; pr = host_rd && hit; d = eng_rxdata;
                oev = eng_push && pre == 32;
            end
            if (pr && pre > 0)  void'(q.pop_front());
            if (pu && pre < 32) q.push_back(d);
        end
        if (uev) und = 1; else if (err_clr) und = 0;
        if (oev) ovr = 1; else if (err_clr) ovr = 0;
        mprev = m;
    endtask

    task automatic step(bit tx, bit rx, bit hw, bit hr, logic [7:0] ad,
                        logic [31:0] wd, bit ep, bit eu, logic [31:0] rd, bit cl);
        @(negedge clk);
        eng_tx_mode = tx; eng_rx_mode = rx; host_wr = hw; host_rd = hr;
        host_addr = ad; host_wdata = wd; eng_pop = ep; eng_push = eu;
        eng_rxdata = rd; err_clr = cl;
        #1;
        compare_all();
        model_update();
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL [watchdog] run did not finish: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        ctx = "R12 reset";
        idle_cycles(2);
        chk("R12 host_rdata", host_rdata, 32'h0);

        ctx = "R1 idle strobes ignored";
        for (int i = 0; i < 4; i++)
            step(0, 0, 1, 1, 8'h20 + 8'(i), 32'hDEAD0000 + i, 1, 1, 32'hBEEF0000 + i, 0);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R2 empty after idle", 32'(flag_empty), 32'd1);

        ctx = "R3 window fill";
        for (int i = 0; i < 36; i++) begin
            step(1, 0, 1, 0, 8'h20 + 8'(i % 32), 32'hA5000000 + i, 0, 0, 0, 0);
            if (i == 10) step(1, 0, 1, 0, 8'h40, 32'h0BAD0BAD, 0, 0, 0, 0);
            if (i == 11) step(1, 0, 1, 0, 8'h1F, 32'h0BAD0BAD, 0, 0, 0, 0);
        end
        ctx = "R11 full write dropped";
        step(1, 0, 1, 0, 8'h3F, 32'hFFFF0000, 1, 0, 0, 0);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R11 count 31 after pop+dropped write", 32'(flag_full), 32'd0);

        ctx = "R4 drain";
        for (int i = 0; i < 20; i++)
            step(1, 0, (i % 3 == 0), 0, 8'h25, 32'hC0DE0000 + i, 1, 0, 0, 0);
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 8'h20, 0, 1, 0, 0, 0);

        ctx = "R5 underrun";
        step(1, 0, 0, 0, 8'h20, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R5 underrun sticky", 32'(flag_underrun), 32'd1);
        ctx = "R4 bypass into empty";
        step(1, 0, 1, 0, 8'h33, 32'h12345678, 0, 0, 0, 0);
        step(1, 0, 1, 0, 8'h34, 32'h9ABCDEF0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 8'h20, 0, 1, 0, 0, 0);

        ctx = "R10 set beats clear";
        step(1, 0, 0, 0, 8'h20, 0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R10 cleared", 32'(flag_underrun), 32'd0);

        ctx = "R10 sticky survives idle";
        step(1, 0, 0, 0, 8'h20, 0, 1, 0, 0, 0);
        idle_cycles(3);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R10 underrun kept", 32'(flag_underrun), 32'd1);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 1);
        idle_cycles(2);

        ctx = "R6 receive fill";
        for (int i = 0; i < 34; i++)
            step(0, 1, 1, 0, 8'h20, 32'h0, 0, 1, 32'h5A000000 + i, 0);
        ctx = "R7 overrun";
        step(0, 1, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R7 overrun sticky", 32'(flag_overrun), 32'd1);
        ctx = "R11 rx full push+pop";
        step(0, 1, 0, 1, 8'h2A, 0, 0, 1, 32'h77777777, 0);
        step(0, 1, 0, 1, 8'h3E, 0, 0, 1, 32'h88888888, 0);
        ctx = "R6 host read out of window";
        step(0, 1, 0, 1, 8'h60, 0, 1, 0, 0, 0);
        ctx = "R9 rx drain";
        for (int i = 0; i < 28; i++)
            step(0, 1, 0, 1, 8'h20 + 8'(i), 0, 0, 0, 0, 0);

        ctx = "R2 direct switch";
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R2 empty after switch", 32'(flag_empty), 32'd1);
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 8'h21, 32'h600D0000 + i, 0, 0, 0, 0);
        step(0, 1, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 8'h20, 0, 0, 0, 0, 0);
        chk("R2 rx empty after switch", 32'(flag_empty), 32'd1);

        ctx = "random mix";
        for (int blk = 0; blk < 20; blk++) begin
            int sel  = int'($urandom % 3);
            int bias = int'($urandom % 4);
            for (int i = 0; i < 80; i++) begin
                logic [7:0] ad = ($urandom % 8 == 0) ? 8'($urandom) : (8'h20 | 8'($urandom % 32));
                bit a = ($urandom % 4) < bias + 1;
                bit b = ($urandom % 4) < 3 - bias + 1;
                step(sel == 1, sel == 2, a, b, ad, $urandom, b, a, $urandom,
                     ($urandom % 16 == 0));
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule